// File: doc/BRIEF.md
# Serial-Bus Node Control and Status Register Decoder

This block is the quadlet register file at the core of a serial-bus node. A request arrives on a single-cycle interface: a byte offset into the register space, a byte length, write data and a write flag. The block decodes the offset and applies a write mask specific to each register. One clock later it returns read data and a response code. It checks alignment on both the offset and the length, and it reports unmapped offsets with their own error code.

The resource-manager registers are the bus manager ID, the available bandwidth and the two channel-availability words. A separate lock unit owns them. This block reads them through input ports from that unit and refuses plain writes to them. Two registers drive the rest of the node when written:

- A write to the node-ID register strobes the new bus number out.
- A write to the cycle-time register strobes its new value toward the cycle counter.

Top module: `sbus_csr_regs`

## Requirements
- R1: A request whose offset or byte length has either of its two low bits set returns response code 6 (type error) and changes no register.
- R2: Every request accepted with `req_valid` high gets exactly one `rsp_valid` pulse on the following clock edge. The response code is 0 (complete), 6 (type error) or 7 (address error). Read data is zero on writes and on errors.
- R3: Split-timeout-high (offset 0x018) stores only bits [2:0] of a write. Split-timeout-low (offset 0x01C) stores only bits [31:19].
- R4: Bus-time (offset 0x204) stores only bits [31:7] of a write. Bits [6:0] read as zero.
- R5: In the broadcast-channel register (offset 0x234) only bit 30, the valid flag, is writable. The word reads 0x8000001F with the flag clear and 0xC000001F with it set.
- R6: Writes to the resource registers return code 6. These registers are bus-manager-ID 0x21C, bandwidth 0x220, channels-high 0x224 and channels-low 0x228.
- R7: A write to node-IDs (offset 0x008) replaces the bus number in bits [31:22] with write-data bits [31:22]. It pulses `bus_id_load` for one cycle with `bus_id_value` holding the new bus number. The node number in bits [21:16] always comes from `node_num`, and bits [15:0] read as zero.
- R8: A write to cycle-time (offset 0x200) stores the full 32-bit word. It pulses `cyc_load` for one cycle with `cyc_value` holding that word.
- R9: Offsets outside the map return code 7 for both reads and writes. So does the busy-timeout offset 0x210.
- R10: Writes to state-clear (0x000), state-set (0x004) and reset-start (0x00C) complete with code 0 and alter no register. Reads of these three offsets return zero.
- R11: Reads of the four resource offsets return the corresponding lock-unit input word with code 0.
- R12: After reset these registers read as follows:

| Register | Reset value |
|---|---|
| Bus number | 0x3FF |
| Split-timeout-high | 0 |
| Split-timeout-low | 0x19000000 |
| Cycle-time | 0 |
| Bus-time | 0 |
| Broadcast-channel | 0x8000001F |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into register space |
| req_len | input | LEN_W | Request length in bytes |
| req_wdata | input | 32 | Write data |
| node_num | input | 6 | Node number from the physical layer |
| res_bus_mgr | input | 32 | Bus-manager-ID word from the lock unit |
| res_bandwidth | input | 32 | Bandwidth-available word from the lock unit |
| res_chan_hi | input | 32 | Channels-available-high word from the lock unit |
| res_chan_lo | input | 32 | Channels-available-low word from the lock unit |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 4 | Response code |
| rsp_rdata | output | 32 | Read data |
| bus_id_load | output | 1 | Bus number updated |
| bus_id_value | output | 10 | Current bus number |
| cyc_load | output | 1 | Cycle-time written |
| cyc_value | output | 32 | Current cycle-time word |

## Verification
The bench builds the block with its default parameters: a 12-bit offset, a 16-bit length and a split-timeout-low reset of 800. With a 12-bit offset, the bench can reach unmapped offsets on both sides of the populated window, including 0xFFC at the top of the space. The non-zero split-timeout-low reset and the fixed broadcast channel 31 make the reset-state reads distinguishable from zero. As a result, a lost reset value or a leaking write mask shows up as a data mismatch.

// File: rtl/sbus_csr_regs.sv
module sbus_csr_regs #(
  parameter int          ADDR_W       = 12,
  parameter int          LEN_W        = 16,
  parameter logic [9:0]  BUS_ID_RST   = 10'h3FF,
  parameter logic [12:0] SPLIT_LO_RST = 13'd800,
  parameter logic [5:0]  BCAST_CHAN   = 6'd31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [31:0]       req_wdata,
  input  logic [5:0]        node_num,
  input  logic [31:0]       res_bus_mgr,
  input  logic [31:0]       res_bandwidth,
  input  logic [31:0]       res_chan_hi,
  input  logic [31:0]       res_chan_lo,
  output logic              rsp_valid,
  output logic [3:0]        rsp_code,
  output logic [31:0]       rsp_rdata,
  output logic              bus_id_load,
  output logic [9:0]        bus_id_value,
  output logic              cyc_load,
  output logic [31:0]       cyc_value
);
  localparam logic [3:0] RC_OK   = 4'd0;
  localparam logic [3:0] RC_TYPE = 4'd6;
  localparam logic [3:0] RC_ADDR = 4'd7;

  localparam logic [ADDR_W-1:0] A_STCLR  = ADDR_W'(32'h000);
  localparam logic [ADDR_W-1:0] A_STSET  = ADDR_W'(32'h004);
  localparam logic [ADDR_W-1:0] A_NODE   = ADDR_W'(32'h008);
  localparam logic [ADDR_W-1:0] A_RSTART = ADDR_W'(32'h00C);
  localparam logic [ADDR_W-1:0] A_SPLHI  = ADDR_W'(32'h018);
  localparam logic [ADDR_W-1:0] A_SPLLO  = ADDR_W'(32'h01C);
  localparam logic [ADDR_W-1:0] A_CYC    = ADDR_W'(32'h200);
  localparam logic [ADDR_W-1:0] A_BUST   = ADDR_W'(32'h204);
  localparam logic [ADDR_W-1:0] A_BMGR   = ADDR_W'(32'h21C);
  localparam logic [ADDR_W-1:0] A_BW     = ADDR_W'(32'h220);
  localparam logic [ADDR_W-1:0] A_CHHI   = ADDR_W'(32'h224);
  localparam logic [ADDR_W-1:0] A_CHLO   = ADDR_W'(32'h228);
  localparam logic [ADDR_W-1:0] A_BCAST  = ADDR_W'(32'h234);

  localparam logic [31:0] BCAST_FIXED = {1'b1, 25'b0, BCAST_CHAN};

  logic [9:0]  bus_id;
  logic [2:0]  split_hi;
  logic [12:0] split_lo;
  logic [31:0] cyc_time;
  logic [24:0] bus_time;
  logic        bcast_valid;

  logic [3:0]  code;
  logic [31:0] rd;
  logic        misaligned;

  assign misaligned = (req_addr[1:0] != 2'b00) || (req_len[1:0] != 2'b00);

  always_comb begin
    code = RC_OK;
    rd   = '0;
    case (req_addr)
      A_STCLR, A_STSET, A_RSTART: rd = '0;
      A_NODE:  rd = {bus_id, node_num, 16'h0};
      A_SPLHI: rd = {29'h0, split_hi};
      A_SPLLO: rd = {split_lo, 19'h0};
      A_CYC:   rd = cyc_time;
      A_BUST:  rd = {bus_time, 7'h0};
      A_BMGR:  begin rd = res_bus_mgr;   if (req_write) code = RC_TYPE; end
      A_BW:    begin rd = res_bandwidth; if (req_write) code = RC_TYPE; end
      A_CHHI:  begin rd = res_chan_hi;   if (req_write) code = RC_TYPE; end
      A_CHLO:  begin rd = res_chan_lo;   if (req_write) code = RC_TYPE; end
      A_BCAST: rd = BCAST_FIXED | {1'b0, bcast_valid, 30'h0};
      default: code = RC_ADDR;
    endcase
    if (misaligned) code = RC_TYPE;
  end

  wire wr_ok = req_valid && req_write && (code == RC_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_id      <= BUS_ID_RST;
      split_hi    <= '0;
      split_lo    <= SPLIT_LO_RST;
      cyc_time    <= '0;
      bus_time    <= '0;
      bcast_valid <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_code    <= RC_OK;
      rsp_rdata   <= '0;
      bus_id_load <= 1'b0;
      cyc_load    <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_code    <= req_valid ? code : RC_OK;
      rsp_rdata   <= (req_valid && !req_write && code == RC_OK) ? rd : '0;
      bus_id_load <= wr_ok && (req_addr == A_NODE);
      cyc_load    <= wr_ok && (req_addr == A_CYC);
      if (wr_ok) begin
        case (req_addr)
          A_NODE:  bus_id      <= req_wdata[31:22];
          A_SPLHI: split_hi    <= req_wdata[2:0];
          A_SPLLO: split_lo    <= req_wdata[31:19];
          A_CYC:   cyc_time    <= req_wdata;
          A_BUST:  bus_time    <= req_wdata[31:7];
          A_BCAST: bcast_valid <= req_wdata[30];
          default: ;
        endcase
      end
    end
  end

  assign bus_id_value = bus_id;
  assign cyc_value    = cyc_time;
endmodule

// File: rtl/sbus_csr_regs_chk.sv
module sbus_csr_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [3:0]        rsp_code,
  input logic [31:0]       rsp_rdata,
  input logic              bus_id_load,
  input logic [9:0]        bus_id_value,
  input logic              cyc_load,
  input logic [31:0]       cyc_value
);
  wire aligned = (req_addr[1:0] == 2'b00) && (req_len[1:0] == 2'b00);
  wire res_hit = (req_addr == ADDR_W'(32'h21C)) || (req_addr == ADDR_W'(32'h220)) ||
                 (req_addr == ADDR_W'(32'h224)) || (req_addr == ADDR_W'(32'h228));

  assert_misaligned_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !aligned |=> rsp_valid && rsp_code == 4'd6);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code == 4'd0 || rsp_code == 4'd6 || rsp_code == 4'd7));

  assert_error_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code != 4'd0 |-> rsp_rdata == 32'h0);

  assert_resource_write_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && aligned && res_hit |=> rsp_code == 4'd6);

  assert_bus_id_load_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && aligned && req_addr == ADDR_W'(32'h008)
      |=> bus_id_load && bus_id_value == $past(req_wdata[31:22]));

  assert_bus_id_load_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_id_load |-> rsp_valid && rsp_code == 4'd0);

  assert_cyc_load_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && aligned && req_addr == ADDR_W'(32'h200)
      |=> cyc_load && cyc_value == $past(req_wdata));

  assert_cyc_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_load |-> $stable(cyc_value));

  assert_busy_timeout_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && aligned && req_addr == ADDR_W'(32'h210) |=> rsp_code == 4'd7);
endmodule

bind sbus_csr_regs sbus_csr_regs_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
  .bus_id_load(bus_id_load), .bus_id_value(bus_id_value),
  .cyc_load(cyc_load), .cyc_value(cyc_value)
);

// File: tb/sbus_csr_regs_tb.sv
module sbus_csr_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [15:0] req_len = 16'd4;
  logic [31:0] req_wdata = '0;
  logic [5:0]  node_num = 6'h2A;
  logic [31:0] res_bus_mgr = 32'h0000_003F;
  logic [31:0] res_bandwidth = 32'h0000_1333;
  logic [31:0] res_chan_hi = 32'h7FFF_FFFE;
  logic [31:0] res_chan_lo = 32'hFFFF_FFFF;
  logic        rsp_valid;
  logic [3:0]  rsp_code;
  logic [31:0] rsp_rdata;
  logic        bus_id_load;
  logic [9:0]  bus_id_value;
  logic        cyc_load;
  logic [31:0] cyc_value;

  int checks = 0;
  int fails = 0;
  logic [3:0]  got_code;
  logic [31:0] got_data;
  logic        got_bload, got_cload, got_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbus_csr_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .node_num(node_num), .res_bus_mgr(res_bus_mgr), .res_bandwidth(res_bandwidth),
    .res_chan_hi(res_chan_hi), .res_chan_lo(res_chan_lo),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
    .bus_id_load(bus_id_load), .bus_id_value(bus_id_value),
    .cyc_load(cyc_load), .cyc_value(cyc_value)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [15:0] len,
                      input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    got_valid = rsp_valid; got_code = rsp_code; got_data = rsp_rdata;
    got_bload = bus_id_load; got_cload = cyc_load;
  endtask

  task automatic test_reset_R12();
    xfer(0, 12'h008, 4, 0); chk("R12 node-ids", got_data, 32'hFFEA_0000);
    xfer(0, 12'h018, 4, 0); chk("R12 split-hi", got_data, 32'h0);
    xfer(0, 12'h01C, 4, 0); chk("R12 split-lo", got_data, 32'h1900_0000);
    xfer(0, 12'h200, 4, 0); chk("R12 cycle", got_data, 32'h0);
    xfer(0, 12'h204, 4, 0); chk("R12 bus-time", got_data, 32'h0);
    xfer(0, 12'h234, 4, 0); chk("R12 bcast", got_data, 32'h8000_001F);
    chk("R2 code read", {28'h0, got_code}, 32'd0);
    chk("R2 valid", {31'h0, got_valid}, 32'd1);
  endtask

  task automatic test_align_R1();
    xfer(1, 12'h01A, 4, 32'hFFFF_FFFF); chk("R1 offset", {28'h0, got_code}, 32'd6);
    xfer(0, 12'h018, 4, 0); chk("R1 no write", got_data, 32'h0);
    xfer(1, 12'h018, 6, 32'hFFFF_FFFF); chk("R1 length", {28'h0, got_code}, 32'd6);
    chk("R2 error data zero", got_data, 32'h0);
    xfer(0, 12'h018, 4, 0); chk("R1 no write len", got_data, 32'h0);
  endtask

  task automatic test_masks_R3_R4();
    xfer(1, 12'h018, 4, 32'hFFFF_FFFF); chk("R3 write ok", {28'h0, got_code}, 32'd0);
    xfer(0, 12'h018, 4, 0); chk("R3 split-hi", got_data, 32'h7);
    xfer(1, 12'h01C, 4, 32'hFFFF_FFFF);
    xfer(0, 12'h01C, 4, 0); chk("R3 split-lo", got_data, 32'hFFF8_0000);
    xfer(1, 12'h204, 4, 32'hFFFF_FFFF);
    xfer(0, 12'h204, 4, 0); chk("R4 bus-time", got_data, 32'hFFFF_FF80);
    xfer(1, 12'h204, 4, 32'h1234_567F);
    xfer(0, 12'h204, 4, 0); chk("R4 bus-time b", got_data, 32'h1234_5600);
  endtask

  task automatic test_bcast_R5();
    xfer(1, 12'h234, 4, 32'hFFFF_FFFF);
    xfer(0, 12'h234, 4, 0); chk("R5 valid set", got_data, 32'hC000_001F);
    xfer(1, 12'h234, 4, 32'h0000_0000);
    xfer(0, 12'h234, 4, 0); chk("R5 valid clr", got_data, 32'h8000_001F);
  endtask

  task automatic test_resource_R6_R11();
    xfer(1, 12'h21C, 4, 0); chk("R6 bus-mgr", {28'h0, got_code}, 32'd6);
    xfer(1, 12'h220, 4, 0); chk("R6 bandwidth", {28'h0, got_code}, 32'd6);
    xfer(1, 12'h224, 4, 0); chk("R6 chan-hi", {28'h0, got_code}, 32'd6);
    xfer(1, 12'h228, 4, 0); chk("R6 chan-lo", {28'h0, got_code}, 32'd6);
    xfer(0, 12'h21C, 4, 0); chk("R11 bus-mgr", got_data, 32'h0000_003F);
    xfer(0, 12'h220, 4, 0); chk("R11 bandwidth", got_data, 32'h0000_1333);
    xfer(0, 12'h224, 4, 0); chk("R11 chan-hi", got_data, 32'h7FFF_FFFE);
    xfer(0, 12'h228, 4, 0); chk("R11 chan-lo", got_data, 32'hFFFF_FFFF);
    chk("R11 code", {28'h0, got_code}, 32'd0);
  endtask

  task automatic test_node_R7();
    xfer(1, 12'h008, 4, 32'h1234_5678);
    chk("R7 load pulse", {31'h0, got_bload}, 32'd1);
    chk("R7 bus value", {22'h0, bus_id_value}, 32'h048);
    @(negedge clk); chk("R7 pulse ends", {31'h0, bus_id_load}, 32'd0);
    node_num = 6'h05;
    xfer(0, 12'h008, 4, 0); chk("R7 readback", got_data, 32'h1205_0000);
  endtask

  task automatic test_cycle_R8();
    xfer(1, 12'h200, 4, 32'hDEAD_BEEF);
    chk("R8 load pulse", {31'h0, got_cload}, 32'd1);
    chk("R8 value", cyc_value, 32'hDEAD_BEEF);
    xfer(0, 12'h200, 4, 0); chk("R8 readback", got_data, 32'hDEAD_BEEF);
    chk("R8 no pulse on read", {31'h0, got_cload}, 32'd0);
  endtask

  task automatic test_gaps_R9();
    xfer(0, 12'h210, 4, 0); chk("R9 busy read", {28'h0, got_code}, 32'd7);
    xfer(1, 12'h210, 4, 0); chk("R9 busy write", {28'h0, got_code}, 32'd7);
    xfer(0, 12'h010, 4, 0); chk("R9 gap low", {28'h0, got_code}, 32'd7);
    xfer(1, 12'h230, 4, 0); chk("R9 gap mid", {28'h0, got_code}, 32'd7);
    xfer(0, 12'hFFC, 4, 0); chk("R9 top", {28'h0, got_code}, 32'd7);
  endtask

  task automatic test_noop_R10();
    xfer(1, 12'h000, 4, 32'hFFFF_FFFF); chk("R10 clr code", {28'h0, got_code}, 32'd0);
    xfer(1, 12'h004, 4, 32'hFFFF_FFFF); chk("R10 set code", {28'h0, got_code}, 32'd0);
    xfer(1, 12'h00C, 4, 32'hFFFF_FFFF); chk("R10 rst code", {28'h0, got_code}, 32'd0);
    chk("R10 no strobes", {30'h0, got_bload, got_cload}, 32'd0);
    xfer(0, 12'h000, 4, 0); chk("R10 clr read", got_data, 32'h0);
    xfer(0, 12'h00C, 4, 0); chk("R10 rst read", got_data, 32'h0);
    xfer(0, 12'h018, 4, 0); chk("R10 split-hi kept", got_data, 32'h7);
    xfer(0, 12'h200, 4, 0); chk("R10 cycle kept", got_data, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle after reset", {31'h0, rsp_valid}, 32'd0);
    test_reset_R12();
    test_align_R1();
    test_masks_R3_R4();
    test_bcast_R5();
    test_resource_R6_R11();
    test_node_R7();
    test_cycle_R8();
    test_gaps_R9();
    test_noop_R10();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule